// File: doc/BRIEF.md
# Segmented Address Translation Unit

This block turns a 32-bit virtual address into a physical address for a processor that splits its address space into four fixed regions. Two kernel regions are translated by removing a fixed base, with no lookup. The user region and the upper kernel region are translated through a small fully associative page buffer. Each region also sets whether the access is cacheable.

A request is a virtual address with a load/store flag, a user-mode flag and an exception-level flag. One cycle later the block answers with either a translation (physical address and cacheable attribute) or an exception (cause code and handler vector). A lookup that finds no entry is reported as a miss. The vector for a miss depends on which mapped region missed. Software fills the page buffer through a write port that updates one entry per clock.

Top module: `seg_xlat_unit`

## Requirements
- R1: An address with bits [31:29] = 3'b100 (0x80000000 to 0x9FFFFFFF) that does not raise an address error translates to the virtual address minus 0x80000000, with no lookup, and is marked cacheable.
- R2: An address with bits [31:29] = 3'b101 (0xA0000000 to 0xBFFFFFFF) that does not raise an address error translates to the virtual address minus 0xA0000000, with no lookup, and is marked uncacheable.
- R3: An address in the user region (bit 31 = 0) or the upper kernel region (bits [31:30] = 2'b11) is looked up by its upper 20 bits. The lookup hits an entry whose valid bit is set and whose 20-bit page number matches. A hit gives the physical address {frame number, address bits [11:0]}, marked cacheable. When several entries match, the lowest index wins.
- R4: A mapped access that finds no matching valid entry raises an exception. The cause is 2'd1 for a load (req_store=0) and 2'd2 for a store (req_store=1).
- R5: A miss in the user region reports vector 0x80000000. A miss in the upper kernel region reports vector 0x80000180, and this holds even when the exception level is set.
- R6: When req_exl is 1, a user-region address translates one-to-one (physical equals virtual) and is marked cacheable, without consulting the buffer. This applies whatever the value of req_user.
- R7: When req_user is 1 and req_exl is 0, any address with bit 31 set raises an exception with cause 2'd3 (address error) and vector 0x80000180, and gives no translation.
- R8: The write port loads entry tlb_wr_idx with the page number, frame number and valid bit given, one entry per clock. A lookup in the same cycle as a write sees the entry's old contents, and from the next cycle on it sees the new ones. An entry written with valid 0 never hits.
- R9: The response appears in the cycle after req_valid is sampled. Exactly one of rsp_ok and rsp_exc is 1 for each request, and both are 0 in a cycle that follows no request. rsp_cause is 2'd0 whenever rsp_ok is 1.
- R10: While rst_n is low, and after it is released, rsp_ok and rsp_exc are 0 and every buffer entry is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A translation request is present this cycle |
| req_vaddr | input | 32 | Virtual address |
| req_store | input | 1 | 1 = store, 0 = load |
| req_user | input | 1 | 1 = user privilege |
| req_exl | input | 1 | Exception level set |
| tlb_wr_en | input | 1 | Write one buffer entry |
| tlb_wr_idx | input | 3 | Entry index to write |
| tlb_wr_vpn | input | 20 | Virtual page number to store |
| tlb_wr_pfn | input | 20 | Physical frame number to store |
| tlb_wr_valid | input | 1 | Valid bit to store |
| rsp_ok | output | 1 | Translation valid |
| rsp_exc | output | 1 | Exception raised |
| rsp_paddr | output | 32 | Physical address (0 on exception) |
| rsp_cacheable | output | 1 | Cacheable attribute (0 on exception) |
| rsp_cause | output | 2 | 0 none, 1 load miss, 2 store miss, 3 address error |
| rsp_vector | output | 32 | Handler vector (0 on translation) |

## Verification
Requests are issued at both edges of each direct region, and the subtracted base and cacheable bit are compared, which tells the two fixed offsets apart. Mapped addresses are tried before and after the buffer is filled, as loads and stores, and with the exception level set and clear. This tells a hit from a miss, the load cause from the store cause, and the refill vector from the general vector. User-mode requests to every kernel region confirm that the privilege check takes priority. A write issued in the same cycle as a lookup of the same entry, followed by a repeat lookup, shows the old-then-new ordering. An entry written with valid 0 shows that a cleared entry never hits.

// File: rtl/seg_xlat_pkg.sv
// Shared constants and types for the segmented address translation unit.
// Assumes a 32-bit virtual address with a fixed four-region layout.
package seg_xlat_pkg;
    localparam int unsigned VA_W = 32;

    localparam logic [VA_W-1:0] K0_BASE     = 32'h8000_0000;
    localparam logic [VA_W-1:0] K1_BASE     = 32'hA000_0000;
    localparam logic [VA_W-1:0] VEC_REFILL  = 32'h8000_0000;
    localparam logic [VA_W-1:0] VEC_GENERAL = 32'h8000_0180;

    typedef enum logic [1:0] {
        CAUSE_NONE    = 2'd0,
        CAUSE_LDMISS  = 2'd1,
        CAUSE_STMISS  = 2'd2,
        CAUSE_ADDRERR = 2'd3
    } cause_e;

    typedef enum logic [1:0] {
        RGN_USER = 2'd0,
        RGN_K0   = 2'd1,
        RGN_K1   = 2'd2,
        RGN_K2   = 2'd3
    } region_e;
endpackage

// File: rtl/seg_region_decode.sv
// Region decoder: classifies a virtual address into one of four fixed
// regions. It gives the mapped and cacheable attributes and the direct
// (base-subtracted) physical address. Purely combinational.
module seg_region_decode
    import seg_xlat_pkg::*;
(
    input  logic [VA_W-1:0] vaddr,
    output region_e         region,
    output logic            mapped,
    output logic            cacheable,
    output logic [VA_W-1:0] direct_pa
);
    // Decode the top three address bits into a region and its attributes.
    always_comb begin
        if (!vaddr[31]) begin
            region    = RGN_USER;
            mapped    = 1'b1;
            cacheable = 1'b1;
            direct_pa = vaddr;
        end else if (vaddr[30]) begin
            region    = RGN_K2;
            mapped    = 1'b1;
            cacheable = 1'b1;
            direct_pa = vaddr;
        end else if (vaddr[29]) begin
            region    = RGN_K1;
            mapped    = 1'b0;
            cacheable = 1'b0;
            direct_pa = vaddr - K1_BASE;
        end else begin
            region    = RGN_K0;
            mapped    = 1'b0;
            cacheable = 1'b1;
            direct_pa = vaddr - K0_BASE;
        end
    end
endmodule

// File: rtl/seg_tlb.sv
// Fully associative page buffer. Each entry holds a page number, a frame
// number and a valid bit. It has one write port and one combinational
// lookup port. A write takes effect at the clock edge, so a lookup in the
// same cycle sees the old contents. The lowest matching index wins.
module seg_tlb #(
    parameter int unsigned ENTRIES = 8,
    parameter int unsigned VPN_W   = 20,
    localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [VPN_W-1:0] wr_vpn,
    input  logic [VPN_W-1:0] wr_pfn,
    input  logic             wr_valid,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             hit,
    output logic [VPN_W-1:0] hit_pfn
);
    logic [VPN_W-1:0] vpn_q [ENTRIES];
    logic [VPN_W-1:0] pfn_q [ENTRIES];
    logic [ENTRIES-1:0] vld_q;
    logic [ENTRIES-1:0] match;

    // Entry storage: reset clears the valid bits; a write updates one entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (wr_idx == IDX_W'(i)) begin
                    vpn_q[i] <= wr_vpn;
                    pfn_q[i] <= wr_pfn;
                    vld_q[i] <= wr_valid;
                end
            end
        end
    end

    // One comparator per entry.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = vld_q[g] && (vpn_q[g] == lk_vpn);
    end

    // Priority select: the lowest matching index provides the frame.
    always_comb begin
        hit_pfn = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) hit_pfn = pfn_q[i];
        end
    end

    assign hit = |match;
endmodule

// File: rtl/seg_xlat_resolve.sv
// Combines the privilege check, the region attributes and the lookup result
// into one response. The priority order is: address error, direct region,
// one-to-one under exception level, buffer hit, miss. Combinational.
module seg_xlat_resolve
    import seg_xlat_pkg::*;
#(
    parameter int unsigned PAGE_W = 12,
    localparam int unsigned VPN_W = VA_W - PAGE_W
) (
    input  logic [VA_W-1:0]  vaddr,
    input  logic             is_store,
    input  logic             is_user,
    input  logic             exl,
    input  region_e          region,
    input  logic             mapped,
    input  logic             cacheable,
    input  logic [VA_W-1:0]  direct_pa,
    input  logic             hit,
    input  logic [VPN_W-1:0] hit_pfn,
    output logic             ok,
    output logic [VA_W-1:0]  paddr,
    output logic             cache_attr,
    output cause_e           cause,
    output logic [VA_W-1:0]  vector
);
    // Choose between a translation and an exception, in priority order.
    always_comb begin
        ok         = 1'b0;
        paddr      = '0;
        cache_attr = 1'b0;
        cause      = CAUSE_NONE;
        vector     = '0;
        if (is_user && !exl && region != RGN_USER) begin
            cause  = CAUSE_ADDRERR;
            vector = VEC_GENERAL;
        end else if (!mapped) begin
            ok         = 1'b1;
            paddr      = direct_pa;
            cache_attr = cacheable;
        end else if (exl && region == RGN_USER) begin
            ok         = 1'b1;
            paddr      = vaddr;
            cache_attr = 1'b1;
        end else if (hit) begin
            ok         = 1'b1;
            paddr      = {hit_pfn, vaddr[PAGE_W-1:0]};
            cache_attr = cacheable;
        end else begin
            cause  = is_store ? CAUSE_STMISS : CAUSE_LDMISS;
            vector = (region == RGN_USER) ? VEC_REFILL : VEC_GENERAL;
        end
    end
endmodule

// File: rtl/seg_xlat_unit.sv
// Top of the segmented address translation unit. It decodes the region,
// looks up the page buffer, resolves the outcome and registers the response
// one cycle after req_valid. Assumes a synchronous active-low reset and a
// page size of 2**PAGE_W bytes.
module seg_xlat_unit
    import seg_xlat_pkg::*;
#(
    parameter int unsigned ENTRIES = 8,
    parameter int unsigned PAGE_W  = 12,
    localparam int unsigned VPN_W  = VA_W - PAGE_W,
    localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [31:0]      req_vaddr,
    input  logic             req_store,
    input  logic             req_user,
    input  logic             req_exl,
    input  logic             tlb_wr_en,
    input  logic [IDX_W-1:0] tlb_wr_idx,
    input  logic [VPN_W-1:0] tlb_wr_vpn,
    input  logic [VPN_W-1:0] tlb_wr_pfn,
    input  logic             tlb_wr_valid,
    output logic             rsp_ok,
    output logic             rsp_exc,
    output logic [31:0]      rsp_paddr,
    output logic             rsp_cacheable,
    output logic [1:0]       rsp_cause,
    output logic [31:0]      rsp_vector
);
    region_e          region;
    logic             mapped, dec_cache;
    logic [VA_W-1:0]  direct_pa;
    logic             hit;
    logic [VPN_W-1:0] hit_pfn;
    logic             ok_c, cache_c;
    logic [VA_W-1:0]  paddr_c, vector_c;
    cause_e           cause_c;

    seg_region_decode u_dec (
        .vaddr     (req_vaddr),
        .region    (region),
        .mapped    (mapped),
        .cacheable (dec_cache),
        .direct_pa (direct_pa)
    );

    seg_tlb #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_tlb (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (tlb_wr_en),
        .wr_idx   (tlb_wr_idx),
        .wr_vpn   (tlb_wr_vpn),
        .wr_pfn   (tlb_wr_pfn),
        .wr_valid (tlb_wr_valid),
        .lk_vpn   (req_vaddr[VA_W-1:PAGE_W]),
        .hit      (hit),
        .hit_pfn  (hit_pfn)
    );

    seg_xlat_resolve #(.PAGE_W(PAGE_W)) u_res (
        .vaddr      (req_vaddr),
        .is_store   (req_store),
        .is_user    (req_user),
        .exl        (req_exl),
        .region     (region),
        .mapped     (mapped),
        .cacheable  (dec_cache),
        .direct_pa  (direct_pa),
        .hit        (hit),
        .hit_pfn    (hit_pfn),
        .ok         (ok_c),
        .paddr      (paddr_c),
        .cache_attr (cache_c),
        .cause      (cause_c),
        .vector     (vector_c)
    );

    // Response register: one cycle after the request; both strobes low otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_ok        <= 1'b0;
            rsp_exc       <= 1'b0;
            rsp_paddr     <= '0;
            rsp_cacheable <= 1'b0;
            rsp_cause     <= CAUSE_NONE;
            rsp_vector    <= '0;
        end else begin
            rsp_ok        <= req_valid && ok_c;
            rsp_exc       <= req_valid && !ok_c;
            rsp_paddr     <= paddr_c;
            rsp_cacheable <= cache_c;
            rsp_cause     <= cause_c;
            rsp_vector    <= vector_c;
        end
    end
endmodule

// File: rtl/seg_xlat_chk.sv
// Property checker for seg_xlat_unit, attached with bind. It watches only
// the ports of the top module.
module seg_xlat_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [31:0] req_vaddr,
    input logic        req_user,
    input logic        req_exl,
    input logic        rsp_ok,
    input logic        rsp_exc,
    input logic [31:0] rsp_paddr,
    input logic        rsp_cacheable,
    input logic [1:0]  rsp_cause,
    input logic [31:0] rsp_vector
);
    assert_one_rsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_ok != rsp_exc));

    assert_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_ok && !rsp_exc));

    assert_ok_nocause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ok |-> (rsp_cause == 2'd0));

    assert_k0_direct_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_vaddr[31:29] == 3'b100 && !(req_user && !req_exl))
        |=> (rsp_ok && rsp_cacheable && rsp_paddr == $past(req_vaddr) - 32'h8000_0000));

    assert_k1_direct_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_vaddr[31:29] == 3'b101 && !(req_user && !req_exl))
        |=> (rsp_ok && !rsp_cacheable && rsp_paddr == $past(req_vaddr) - 32'hA000_0000));

    assert_user_vector_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_vaddr[31] && !req_exl)
        |=> (!rsp_exc || rsp_vector == 32'h8000_0000));

    assert_exl_identity_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_exl && !req_vaddr[31])
        |=> (rsp_ok && rsp_cacheable && rsp_paddr == $past(req_vaddr)));

    assert_addr_error_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_user && !req_exl && req_vaddr[31])
        |=> (rsp_exc && rsp_cause == 2'd3 && rsp_vector == 32'h8000_0180));
endmodule

bind seg_xlat_unit seg_xlat_chk u_chk (.*);

// File: tb/seg_xlat_unit_bench.sv
// Scoreboard bench: driver tasks push expected responses, and a monitor
// pops and compares them one cycle later.
module seg_xlat_unit_bench;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic        ok;
        logic [31:0] pa;
        logic        c;
        logic [1:0]  cause;
        logic [31:0] vec;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        req_store = 1'b0, req_user = 1'b0, req_exl = 1'b0;
    logic        tlb_wr_en = 1'b0;
    logic [2:0]  tlb_wr_idx = '0;
    logic [19:0] tlb_wr_vpn = '0, tlb_wr_pfn = '0;
    logic        tlb_wr_valid = 1'b0;
    logic        rsp_ok, rsp_exc, rsp_cacheable;
    logic [31:0] rsp_paddr, rsp_vector;
    logic [1:0]  rsp_cause;

    int nchk = 0, nerr = 0;
    bit mon_on = 1'b0, done = 1'b0;
    exp_t  q[$];
    string tq[$];

    logic [19:0] m_vpn [8];
    logic [19:0] m_pfn [8];
    logic [7:0]  m_vld = '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    seg_xlat_unit u_seg_xlat_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_store(req_store), .req_user(req_user), .req_exl(req_exl),
        .tlb_wr_en(tlb_wr_en), .tlb_wr_idx(tlb_wr_idx), .tlb_wr_vpn(tlb_wr_vpn),
        .tlb_wr_pfn(tlb_wr_pfn), .tlb_wr_valid(tlb_wr_valid),
        .rsp_ok(rsp_ok), .rsp_exc(rsp_exc), .rsp_paddr(rsp_paddr),
        .rsp_cacheable(rsp_cacheable), .rsp_cause(rsp_cause), .rsp_vector(rsp_vector)
    );

    task automatic chk(input bit cond, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!cond) begin
            nerr++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Expected response derived from the requirements.
    function automatic exp_t model(input logic [31:0] va, input logic st,
                                   input logic us, input logic ex);
        exp_t e;
        bit found;
        e = '0;
        found = 1'b0;
        if (us && !ex && va[31]) begin
            e.cause = 2'd3; e.vec = 32'h8000_0180;                   // R7
        end else if (va[31:29] == 3'b100) begin
            e.ok = 1'b1; e.pa = va - 32'h8000_0000; e.c = 1'b1;      // R1
        end else if (va[31:29] == 3'b101) begin
            e.ok = 1'b1; e.pa = va - 32'hA000_0000; e.c = 1'b0;      // R2
        end else if (!va[31] && ex) begin
            e.ok = 1'b1; e.pa = va; e.c = 1'b1;                      // R6
        end else begin
            for (int i = 0; i < 8; i++) begin
                if (!found && m_vld[i] && m_vpn[i] == va[31:12]) begin
                    found = 1'b1;
                    e.ok = 1'b1; e.pa = {m_pfn[i], va[11:0]}; e.c = 1'b1;  // R3
                end
            end
            if (!found) begin
                e.cause = st ? 2'd2 : 2'd1;                          // R4
                e.vec = va[31] ? 32'h8000_0180 : 32'h8000_0000;      // R5
            end
        end
        return e;
    endfunction

    // Driver: a request with an optional write in the same cycle.
    task automatic access_wr(input logic [31:0] va, input logic st, input logic us,
                             input logic ex, input logic wr, input logic [2:0] idx,
                             input logic [19:0] vpn, input logic [19:0] pfn,
                             input logic v, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_store = st; req_user = us; req_exl = ex;
        tlb_wr_en = wr; tlb_wr_idx = idx; tlb_wr_vpn = vpn; tlb_wr_pfn = pfn;
        tlb_wr_valid = v;
        q.push_back(model(va, st, us, ex));
        tq.push_back(tag);
        if (wr) begin
            m_vpn[idx] = vpn; m_pfn[idx] = pfn; m_vld[idx] = v;
        end
    endtask

    task automatic access(input logic [31:0] va, input logic st, input logic us,
                          input logic ex, input string tag);
        access_wr(va, st, us, ex, 1'b0, 3'd0, 20'd0, 20'd0, 1'b0, tag);
    endtask

    task automatic tlb_write(input logic [2:0] idx, input logic [19:0] vpn,
                             input logic [19:0] pfn, input logic v);
        @(negedge clk);
        req_valid = 1'b0;
        tlb_wr_en = 1'b1; tlb_wr_idx = idx; tlb_wr_vpn = vpn; tlb_wr_pfn = pfn;
        tlb_wr_valid = v;
        m_vpn[idx] = vpn; m_pfn[idx] = pfn; m_vld[idx] = v;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            req_valid = 1'b0; tlb_wr_en = 1'b0;
        end
    endtask

    // Monitor: one cycle after each request, compare against the queue head.
    always @(posedge clk) begin
        #1;
        if (mon_on) begin
            if (q.size() > 0) begin
                exp_t e;
                string t;
                e = q.pop_front();
                t = tq.pop_front();
                if (e.ok) begin
                    chk(rsp_ok && !rsp_exc, t, "ok/exc", {30'd0, rsp_ok, rsp_exc}, 32'd2);
                    chk(rsp_paddr == e.pa, t, "paddr", rsp_paddr, e.pa);
                    chk(rsp_cacheable == e.c, t, "cacheable", {31'd0, rsp_cacheable}, {31'd0, e.c});
                    chk(rsp_cause == 2'd0, {t, "/R9"}, "cause", {30'd0, rsp_cause}, 32'd0);
                end else begin
                    chk(rsp_exc && !rsp_ok, t, "ok/exc", {30'd0, rsp_ok, rsp_exc}, 32'd1);
                    chk(rsp_cause == e.cause, t, "cause", {30'd0, rsp_cause}, {30'd0, e.cause});
                    chk(rsp_vector == e.vec, t, "vector", rsp_vector, e.vec);
                end
            end else begin
                chk(!rsp_ok && !rsp_exc, "R9", "idle strobes", {30'd0, rsp_ok, rsp_exc}, 32'd0);
            end
        end
    end

    // Watchdog: counts as a failed check and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nerr++; nchk++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!rsp_ok && !rsp_exc, "R10", "strobes in reset", {30'd0, rsp_ok, rsp_exc}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!rsp_ok && !rsp_exc, "R10", "strobes after reset", {30'd0, rsp_ok, rsp_exc}, 32'd0);
        mon_on = 1'b1;

        // Direct regions, both edges.
        access(32'h8000_1234, 1'b0, 1'b0, 1'b0, "R1");
        access(32'h9FFF_FFFF, 1'b1, 1'b0, 1'b0, "R1");
        access(32'hA000_0000, 1'b0, 1'b0, 1'b0, "R2");
        access(32'hBFFF_FFFC, 1'b1, 1'b0, 1'b0, "R2");
        // Misses with an empty buffer after reset.
        access(32'h0040_0010, 1'b0, 1'b0, 1'b0, "R10");
        access(32'h0040_0010, 1'b1, 1'b1, 1'b0, "R4");
        access(32'hC000_2000, 1'b0, 1'b0, 1'b0, "R5");
        access(32'hC000_2000, 1'b1, 1'b0, 1'b0, "R4");
        idle(2);

        // Fill, then hit in both mapped regions.
        tlb_write(3'd0, 20'h00400, 20'h01234, 1'b1);
        tlb_write(3'd5, 20'hC0002, 20'h00ABC, 1'b1);
        tlb_write(3'd7, 20'h7FFFF, 20'hFFFFF, 1'b1);
        access(32'h0040_0ABC, 1'b0, 1'b1, 1'b0, "R3");
        access(32'hC000_2FFF, 1'b1, 1'b0, 1'b0, "R3");
        access(32'h7FFF_F000, 1'b0, 1'b1, 1'b0, "R3");
        tlb_write(3'd3, 20'h00400, 20'h0BEEF, 1'b1);
        access(32'h0040_0001, 1'b0, 1'b0, 1'b0, "R3");

        // Exception level: user region one-to-one, upper kernel still mapped.
        access(32'h1234_5678, 1'b0, 1'b0, 1'b1, "R6");
        access(32'h1234_5678, 1'b1, 1'b1, 1'b1, "R6");
        access(32'hC000_3000, 1'b0, 1'b0, 1'b1, "R5");

        // User-mode access to kernel addresses.
        access(32'h8000_0000, 1'b0, 1'b1, 1'b0, "R7");
        access(32'hFFFF_FFF0, 1'b1, 1'b1, 1'b0, "R7");
        access(32'hA000_0000, 1'b0, 1'b1, 1'b0, "R7");
        access(32'hC000_2000, 1'b0, 1'b1, 1'b0, "R7");

        // Same-cycle write sees old contents; the next lookup sees the new ones.
        access_wr(32'h0040_0000, 1'b0, 1'b0, 1'b0, 1'b1, 3'd0, 20'h00400,
                  20'h00055, 1'b1, "R8");
        access(32'h0040_0000, 1'b0, 1'b0, 1'b0, "R8");
        access_wr(32'hC000_2004, 1'b0, 1'b0, 1'b0, 1'b1, 3'd5, 20'hC0002,
                  20'h00ABC, 1'b0, "R8");
        access(32'hC000_2004, 1'b1, 1'b0, 1'b0, "R8");
        tlb_write(3'd2, 20'h12345, 20'h11111, 1'b0);
        access(32'h1234_5000, 1'b0, 1'b1, 1'b0, "R8");
        idle(4);

        chk(q.size() == 0, "R9", "responses outstanding", q.size(), 32'd0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule